// File: doc/BRIEF.md
# Channel-Tagged Stream Pattern Generator and Checker

This block exercises a multi-channel data path with a known, self-describing pattern. Its generator half sends framed records of 16-bit words over a valid/ready stream. A record opens with a header word that names the sending board. Every channel then contributes a short run of words, and a trailer word closes the record with a rolling sequence number. Each data word carries its own channel number and its position within the run, so any word can be recognised wherever it lands.

The checker half takes a stream that has passed through the path under test. It rebuilds the sequence it expects and sorts each fault into a class: a framing fault (words missing or extra before the trailer), a value fault (wrong content, out-of-order words, a bad header source or a bad trailer sequence) or a byte-order fault (the two bytes of a word are exchanged). Each class has a saturating counter on a status port. After a fault the checker drops the rest of the record and waits for the next header, so one damaged record adds one count.

The generator either sends a single record and stops, or repeats records for as long as the continuous-mode input stays high. A run start clears the error counts and restarts the sequence numbering on both halves.

Top module: `chan_pattern_unit`

## Requirements
- R1: A record has twelve channels, numbered 0 to 11 and sent in ascending order. Each channel sends eight data words, whose upper byte is the channel number and whose lower byte is the position, counting 0 to 7.
- R2: A record starts with the header word {0xA5, src_id} and ends with the trailer word {0x5A, seq}. After a run start, seq is 0 in the first record and rises by one (modulo 256) in each later record.
- R3: With run_cont low, a run start produces exactly one record of 98 words, after which gen_valid stays low.
- R4: With run_cont high, records follow back to back. After run_cont falls, the generator completes the record in progress and then stops.
- R5: A generator word counts as transferred only in a cycle where gen_valid and gen_ready are both high. While gen_ready is low, gen_valid stays high and gen_data does not change.
- R6: A well-formed stream of records raises no error counter.
- R7: If a data word differs from the expected word (this includes a word shifted by an earlier missing word), err_value rises by one. The rest of that record is ignored until the next header.
- R8: If a data word equals the expected word with its two bytes exchanged, err_endian rises by one and err_value does not change.
- R9: If a trailer arrives before all data words, or a non-trailer word arrives where the trailer is due, err_frame rises by one. No single word raises more than one counter.
- R10: A trailer whose sequence byte does not match the header count since the run start raises err_value by one. A header with a source byte other than src_id raises err_value by one and does not open a record.
- R11: Each error counter is 16 bits wide and holds at 0xFFFF once it gets there.
- R12: All error counters go to zero on chk_clear and on run_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Pulse that starts a run and clears counts and sequence numbers |
| run_cont | input | 1 | High selects continuous mode; low selects a single record |
| src_id | input | 8 | Source byte placed in headers and expected by the checker |
| gen_valid | output | 1 | Generator word available |
| gen_ready | input | 1 | Downstream accepts the generator word |
| gen_data | output | 16 | Generator word |
| chk_valid | input | 1 | Word presented to the checker (always accepted) |
| chk_data | input | 16 | Checker input word |
| chk_clear | input | 1 | Clears the error counters |
| err_frame | output | 16 | Framing error count |
| err_value | output | 16 | Value error count |
| err_endian | output | 16 | Byte-order error count |

## Verification
Some properties are checked by the assertions in every cycle. A stalled generator word must stay unchanged. A single-mode run must drop valid after its trailer. Data words must carry fields that are within range. A single word must never raise more than one counter. The counters must hold at the top value, never fall except on a clear, and read zero after a clear. Other behaviour depends on a whole record or a chosen fault, so only the bench scenarios can show it: the exact word order and sequence numbers, how a fault is classed, recovery at the next header, and when continuous mode stops. These scenarios are a loopback run and a table of injected faults.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

    typedef logic [15:0] word_t;

    localparam logic [7:0] HDR_TAG = 8'hA5;
    localparam logic [7:0] TRL_TAG = 8'h5A;

    typedef enum logic [1:0] {G_IDLE, G_HDR, G_DATA, G_TRL} gen_state_e;
    typedef enum logic [1:0] {C_WAIT, C_DATA, C_TRL} chk_state_e;

    typedef struct packed {
        logic frame;
        logic value;
        logic endian;
    } err_inc_t;

    function automatic word_t swap_bytes(word_t w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/pat_gen.sv
module pat_gen
    import patgen_pkg::*;
#(
    parameter int N_CH  = 12,
    parameter int N_POS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cont,
    input  logic [7:0]  src_id,
    output logic        out_valid,
    input  logic        out_ready,
    output word_t       out_data
);
    localparam int CH_W  = (N_CH  > 1) ? $clog2(N_CH)  : 1;
    localparam int POS_W = (N_POS > 1) ? $clog2(N_POS) : 1;

    gen_state_e       state;
    logic [CH_W-1:0]  ch;
    logic [POS_W-1:0] pos;
    logic [7:0]       seq;
    logic             fire, last_ch, last_pos;

    assign out_valid = (state != G_IDLE);
    assign fire      = out_valid && out_ready;
    assign last_ch   = (ch  == CH_W'(N_CH - 1));
    assign last_pos  = (pos == POS_W'(N_POS - 1));

    always_comb begin
        case (state)
            G_HDR:   out_data = {HDR_TAG, src_id};
            G_DATA:  out_data = {8'(ch), 8'(pos)};
            G_TRL:   out_data = {TRL_TAG, seq};
            default: out_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= G_IDLE;
            ch    <= '0;
            pos   <= '0;
            seq   <= '0;
        end else if (start) begin
            state <= G_HDR;
            ch    <= '0;
            pos   <= '0;
            seq   <= '0;
        end else if (fire) begin
            case (state)
                G_HDR: state <= G_DATA;
                G_DATA: begin
                    if (last_pos) begin
                        pos <= '0;
                        if (last_ch) begin
                            ch    <= '0;
                            state <= G_TRL;
                        end else begin
                            ch <= ch + 1'b1;
                        end
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                G_TRL: begin
                    seq   <= seq + 8'd1;
                    state <= cont ? G_HDR : G_IDLE;
                end
                default: state <= G_IDLE;
            endcase
        end
    end

    // R5: a stalled word is held unchanged
    assert_hold_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

    // R3: single mode stops after its trailer
    assert_single_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (state == G_TRL && fire && !cont && !start) |=> !out_valid);

    // R1: data word fields stay inside channel and position range
    assert_word_fields_R1: assert property (@(posedge clk) disable iff (rst)
        (state == G_DATA) |-> (out_data[15:8] < 8'(N_CH) && out_data[7:0] < 8'(N_POS)));

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != '1)
            cnt <= cnt + 1'b1;
    end

    assert_saturate_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && !clr) |=> (cnt == '1));

    assert_monotonic_R11: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

    assert_clear_R12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/pat_chk.sv
module pat_chk
    import patgen_pkg::*;
#(
    parameter int N_CH  = 12,
    parameter int N_POS = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             clr,
    input  logic [7:0]       src_id,
    input  logic             in_valid,
    input  word_t            in_data,
    output logic [CNT_W-1:0] err_frame,
    output logic [CNT_W-1:0] err_value,
    output logic [CNT_W-1:0] err_endian
);
    localparam int CH_W  = (N_CH  > 1) ? $clog2(N_CH)  : 1;
    localparam int POS_W = (N_POS > 1) ? $clog2(N_POS) : 1;
    localparam int N_CNT = 3;

    chk_state_e       state, state_n;
    logic [CH_W-1:0]  ch, ch_n;
    logic [POS_W-1:0] pos, pos_n;
    logic [7:0]       next_seq, next_seq_n, cur_seq, cur_seq_n;
    err_inc_t         inc;
    word_t            exp_word;
    logic             last_ch, last_pos;

    assign exp_word = {8'(ch), 8'(pos)};
    assign last_ch  = (ch  == CH_W'(N_CH - 1));
    assign last_pos = (pos == POS_W'(N_POS - 1));

    always_comb begin
        state_n    = state;
        ch_n       = ch;
        pos_n      = pos;
        next_seq_n = next_seq;
        cur_seq_n  = cur_seq;
        inc        = '0;
        if (in_valid) begin
            case (state)
                C_WAIT: begin
                    if (in_data[15:8] == HDR_TAG) begin
                        if (in_data[7:0] == src_id) begin
                            state_n    = C_DATA;
                            ch_n       = '0;
                            pos_n      = '0;
                            cur_seq_n  = next_seq;
                            next_seq_n = next_seq + 8'd1;
                        end else begin
                            inc.value = 1'b1;
                        end
                    end
                end
                C_DATA: begin
                    if (in_data == exp_word) begin
                        if (last_pos) begin
                            pos_n = '0;
                            if (last_ch) state_n = C_TRL;
                            else         ch_n = ch + 1'b1;
                        end else begin
                            pos_n = pos + 1'b1;
                        end
                    end else begin
                        state_n = C_WAIT;
                        if (in_data[15:8] == TRL_TAG)             inc.frame  = 1'b1;
                        else if (swap_bytes(in_data) == exp_word) inc.endian = 1'b1;
                        else                                      inc.value  = 1'b1;
                    end
                end
                C_TRL: begin
                    state_n = C_WAIT;
                    if (in_data[15:8] != TRL_TAG)     inc.frame = 1'b1;
                    else if (in_data[7:0] != cur_seq) inc.value = 1'b1;
                end
                default: state_n = C_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state    <= C_WAIT;
            ch       <= '0;
            pos      <= '0;
            next_seq <= '0;
            cur_seq  <= '0;
        end else begin
            state    <= state_n;
            ch       <= ch_n;
            pos      <= pos_n;
            next_seq <= next_seq_n;
            cur_seq  <= cur_seq_n;
        end
    end

    logic [N_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt [N_CNT];

    assign inc_vec = {inc.frame, inc.value, inc.endian};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .inc (inc_vec[g]),
            .cnt (cnt[g])
        );
    end

    assign err_frame  = cnt[2];
    assign err_value  = cnt[1];
    assign err_endian = cnt[0];

    // R9: one word never raises more than one error class
    assert_one_class_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(inc_vec));

endmodule

// File: rtl/chan_pattern_unit.sv
module chan_pattern_unit
    import patgen_pkg::*;
#(
    parameter int N_CH  = 12,
    parameter int N_POS = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_start,
    input  logic             run_cont,
    input  logic [7:0]       src_id,
    output logic             gen_valid,
    input  logic             gen_ready,
    output logic [15:0]      gen_data,
    input  logic             chk_valid,
    input  logic [15:0]      chk_data,
    input  logic             chk_clear,
    output logic [CNT_W-1:0] err_frame,
    output logic [CNT_W-1:0] err_value,
    output logic [CNT_W-1:0] err_endian
);
    pat_gen #(.N_CH(N_CH), .N_POS(N_POS)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (run_start),
        .cont      (run_cont),
        .src_id    (src_id),
        .out_valid (gen_valid),
        .out_ready (gen_ready),
        .out_data  (gen_data)
    );

    pat_chk #(.N_CH(N_CH), .N_POS(N_POS), .CNT_W(CNT_W)) u_chk (
        .clk        (clk),
        .rst        (rst),
        .restart    (run_start),
        .clr        (chk_clear || run_start),
        .src_id     (src_id),
        .in_valid   (chk_valid),
        .in_data    (chk_data),
        .err_frame  (err_frame),
        .err_value  (err_value),
        .err_endian (err_endian)
    );
endmodule

// File: tb/sim_chan_pattern_unit.sv
module sim_chan_pattern_unit;
    localparam int REC = 98;
    localparam logic [7:0] SRC = 8'h3C;

    logic clk = 1'b0, rst = 1'b1;
    logic run_start = 1'b0, run_cont = 1'b0, gen_ready = 1'b0, chk_clear = 1'b0;
    logic gen_valid, chk_valid;
    logic [15:0] gen_data, chk_data, inj_data = '0;
    logic inj_valid = 1'b0, loopback = 1'b0;
    logic [15:0] err_frame, err_value, err_endian;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, mon_idx = 0, mon_words = 0;
    logic [7:0] mon_seq = '0;
    bit mon_on = 0, rdy_toggle = 0, rdy_level = 0, prev_stall = 0;
    logic [15:0] prev_data = '0;

    always #10 clk = ~clk;

    assign chk_valid = loopback ? (gen_valid && gen_ready) : inj_valid;
    assign chk_data  = loopback ? gen_data : inj_data;

    chan_pattern_unit u0 (
        .clk(clk), .rst(rst), .run_start(run_start), .run_cont(run_cont),
        .src_id(SRC), .gen_valid(gen_valid), .gen_ready(gen_ready),
        .gen_data(gen_data), .chk_valid(chk_valid), .chk_data(chk_data),
        .chk_clear(chk_clear), .err_frame(err_frame), .err_value(err_value),
        .err_endian(err_endian)
    );

    // kind[14:11] idx[10:3] value[2] endian[1] frame[0]
    // kinds: 0 clean, 1 bit flip, 2 byte swap, 3 drop, 4 extra before trailer, 5 bad trailer seq
    localparam logic [14:0] CASES [8] = '{
        {4'd0, 8'd0,  3'b000},
        {4'd1, 8'd20, 3'b100},
        {4'd2, 8'd30, 3'b010},
        {4'd3, 8'd96, 3'b001},
        {4'd4, 8'd97, 3'b001},
        {4'd5, 8'd97, 3'b100},
        {4'd3, 8'd50, 3'b100},
        {4'd0, 8'd0,  3'b000}
    };

    function automatic logic [15:0] word_at(int i, logic [7:0] sq);
        if (i == 0)        return {8'hA5, SRC};
        else if (i == 97)  return {8'h5A, sq};
        else               return {8'((i - 1) / 8), 8'((i - 1) % 8)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: sets ready for the coming edge, then judges transfers and stalls
    always @(negedge clk) begin
        if (mon_on && prev_stall)
            check(gen_valid && gen_data == prev_data, "R5", int'(gen_data), int'(prev_data));
        cyc++;
        gen_ready = rdy_toggle ? (cyc % 3 != 2) : rdy_level;
        if (mon_on && gen_valid && gen_ready) begin
            check(gen_data == word_at(mon_idx, mon_seq),
                  (mon_idx == 0 || mon_idx == 97) ? "R2" : "R1",
                  int'(gen_data), int'(word_at(mon_idx, mon_seq)));
            mon_words++;
            mon_idx++;
            if (mon_idx == REC) begin
                mon_idx = 0;
                mon_seq = mon_seq + 8'd1;
            end
        end
        prev_stall = gen_valid && !gen_ready;
        prev_data  = gen_data;
    end

    task automatic pulse_start();
        @(negedge clk);
        run_start = 1'b1;
        mon_idx = 0; mon_seq = '0; mon_words = 0;
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        inj_valid = 1'b1;
        inj_data  = w;
    endtask

    task automatic send_record(input int kind, input int idx, input logic [7:0] sq);
        for (int i = 0; i < REC; i++) begin
            logic [15:0] w;
            w = word_at(i, sq);
            if (kind == 4 && i == 97) send(16'h0B07);
            if (i == idx && kind == 1) w = w ^ 16'h0010;
            if (i == idx && kind == 2) w = {w[7:0], w[15:8]};
            if (i == idx && kind == 5) w = w ^ 16'h0001;
            if (!(i == idx && kind == 3)) send(w);
        end
        @(negedge clk);
        inj_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] s;
        int fb, vb, eb, t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(gen_valid == 1'b0, "R3", int'(gen_valid), 0);
        check(err_frame == 0 && err_value == 0 && err_endian == 0, "R12",
              int'(err_frame) + int'(err_value) + int'(err_endian), 0);

        // Single record with a stalling consumer
        mon_on = 1; rdy_toggle = 1; run_cont = 1'b0;
        pulse_start();
        t = 0;
        while (gen_valid && t < 1000) begin @(negedge clk); t++; end
        check(mon_words == REC, "R3", mon_words, REC);
        repeat (20) begin
            @(negedge clk);
            check(!gen_valid, "R3", int'(gen_valid), 0);
        end

        // Continuous run looped back into the checker
        rdy_toggle = 0; rdy_level = 1; loopback = 1; run_cont = 1'b1;
        pulse_start();
        while (mon_words < 110) @(negedge clk);
        run_cont = 1'b0;
        t = 0;
        while (gen_valid && t < 1000) begin @(negedge clk); t++; end
        check(mon_words == 2 * REC, "R4", mon_words, 2 * REC);
        check(mon_seq == 8'd2, "R2", int'(mon_seq), 2);
        @(negedge clk);
        check(err_frame == 0 && err_value == 0 && err_endian == 0, "R6",
              int'(err_frame) + int'(err_value) + int'(err_endian), 0);
        loopback = 0; mon_on = 0; rdy_level = 0;

        // Fault table walked on the injected input
        pulse_start();
        s = '0;
        for (int k = 0; k < 8; k++) begin
            logic [14:0] e;
            string req;
            e  = CASES[k];
            fb = int'(err_frame); vb = int'(err_value); eb = int'(err_endian);
            send_record(int'(e[14:11]), int'(e[10:3]), s);
            s = s + 8'd1;
            if (e[0])                  req = "R9";
            else if (e[1])             req = "R8";
            else if (e[14:11] == 4'd5) req = "R10";
            else if (e[2])             req = "R7";
            else                       req = "R6";
            check(int'(err_value)  - vb == int'(e[2]), req, int'(err_value)  - vb, int'(e[2]));
            check(int'(err_endian) - eb == int'(e[1]), req, int'(err_endian) - eb, int'(e[1]));
            check(int'(err_frame)  - fb == int'(e[0]), req, int'(err_frame)  - fb, int'(e[0]));
        end

        // Bad source headers: value errors, then saturation
        vb = int'(err_value);
        for (int i = 0; i < 3; i++) send({8'hA5, SRC ^ 8'h01});
        @(negedge clk); inj_valid = 1'b0; @(negedge clk);
        check(int'(err_value) - vb == 3, "R10", int'(err_value) - vb, 3);
        for (int i = 0; i < 65540; i++) send({8'hA5, SRC ^ 8'h01});
        @(negedge clk); inj_valid = 1'b0; @(negedge clk);
        check(err_value == 16'hFFFF, "R11", int'(err_value), 65535);
        check(err_frame == 16'd2, "R11", int'(err_frame), 2);

        // Clearing
        @(negedge clk); chk_clear = 1'b1;
        @(negedge clk); chk_clear = 1'b0;
        check(err_value == 0 && err_frame == 0 && err_endian == 0, "R12",
              int'(err_value) + int'(err_frame) + int'(err_endian), 0);
        send({8'hA5, SRC ^ 8'h01});
        @(negedge clk); inj_valid = 1'b0; @(negedge clk);
        check(err_value == 16'd1, "R10", int'(err_value), 1);
        pulse_start();
        check(err_value == 0, "R12", int'(err_value), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule